// File: doc/BRIEF.md
# Double-Buffered Compare Timer Channel

This block is one 16-bit timer channel built around a binary up-counter. Each count step is gated by one of four sources: three prescaler tap enables (divide-by-1, divide-by-4 and divide-by-16) that arrive as single-cycle strobes from a divider outside the block, or rising edges on an external clock pin. The pin is synchronized onto the system clock, so the whole channel runs in one clock domain.

Two compare registers watch the counter. Each has its own match pulse output. The second compare register can also act as the period limit: with clear-on-match enabled, the counter returns to zero on the count step after it reaches that value. When the counter wraps from all-ones to zero, it raises a one-cycle overflow interrupt pulse.

Software writes the compare values through a write buffer. With double buffering on and the counter running, a new value waits in the buffer and moves into the active compare register only when the counter hits compare register 1. This lets a period and duty cycle change together at a period boundary. When double buffering is off, or while the counter is stopped, writes take effect at once. Configuration arrives over a simple write-enable, address and data port.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset the counter reads 0, all pulse outputs are low, double buffering is off, clear-on-match is off, the channel is stopped and both compare values are 0.
- R2: Register map by address: 0 is control, 1 is compare 0, 2 is compare 1, 3 is ignored. Control bits are run at bit 0, clock select at bits 2:1, clear-on-match at bit 3 and double-buffer enable at bit 4. With run at 1, the counter adds one on each selected count enable and holds its value in every other cycle.
- R3: With run at 0 the counter is zero from the cycle after the control write that clears run, and it stays at zero.
- R4: Clock select code 0 takes the divide-by-1 tap, code 1 the divide-by-4 tap, code 2 the divide-by-16 tap and code 3 the synchronized external pin.
- R5: The compare 0 match output is high for exactly the one cycle in which the counter first shows a value that equals compare 0 after a count step.
- R6: The compare 1 match output behaves the same way against compare 1. With clear-on-match at 1, the count step after a compare 1 match loads 0. With clear-on-match at 0, the counter continues past the compare value.
- R7: A count step from 16'hFFFF to 0 that is not a clear-on-match makes the overflow output high for one cycle, in the cycle in which the counter first shows 0.
- R8: The external pin passes through a two-flop synchronizer. Each rising edge gives exactly one count step.
- R9: With double buffering on and the counter running, a compare write goes only to the buffer. The buffered values move into both compare registers in the cycle of a compare 1 match and are in force from the next cycle.
- R10: While the counter is stopped, a compare write updates the active compare register at once, even with double buffering on.
- R11: With double buffering off, a compare write updates the active compare register at once while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 16 | Register write data |
| tickDiv1 | input | 1 | Divide-by-1 prescaler enable |
| tickDiv4 | input | 1 | Divide-by-4 prescaler enable |
| tickDiv16 | input | 1 | Divide-by-16 prescaler enable |
| extClkIn | input | 1 | Asynchronous external count clock |
| countVal | output | 16 | Current counter value |
| match0Pulse | output | 1 | Compare 0 match pulse |
| match1Pulse | output | 1 | Compare 1 match pulse |
| ovfIrq | output | 1 | Overflow interrupt pulse |

## Verification
The assertions assume that prescaler taps are single-cycle strobes and that a compare 1 write never lands in the same cycle as a compare 1 reload. They also assume that the external pin stays at each level for longer than the synchronizer depth. The bench meets these assumptions as follows. It drives the taps from its own free-running counter. It keeps every buffered write several cycles away from the match that reloads it. It holds each external level for four clock cycles.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CMP0 = 2'd1,
    ADDR_CMP1 = 2'd2,
    ADDR_NONE = 2'd3
  } regAddrE;

  typedef enum logic [1:0] {
    SEL_DIV1  = 2'd0,
    SEL_DIV4  = 2'd1,
    SEL_DIV16 = 2'd2,
    SEL_EXT   = 2'd3
  } clkSelE;

  // control word bit positions
  localparam int RunBit    = 0;
  localparam int SelLo     = 1;
  localparam int SelHi     = 2;
  localparam int ClrBit    = 3;
  localparam int DblBufBit = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;     // one count step this cycle
    logic holdZero;    // channel stopped: force counter to zero
    logic clrOnMatch;  // clear-on-match with compare 1
  } dpStrobeT;

endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int CntW       = 16,
  parameter int SyncStages = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [1:0]             regAddr,
  input  logic [CntW-1:0]        regWdata,
  input  logic                   tickDiv1,
  input  logic                   tickDiv4,
  input  logic                   tickDiv16,
  input  logic                   extClkIn,
  input  logic                   reloadHit,
  output dpStrobeT               strb,
  output logic [1:0][CntW-1:0]   cmpAct
);

  localparam int SyncTop = SyncStages - 1;
  localparam int NumCmp  = 2;

  logic   runQ;
  logic   clrEnQ;
  logic   dblBufQ;
  clkSelE clkSelQ;

  logic ctrlWr;
  assign ctrlWr = regWe && (regAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      clrEnQ  <= 1'b0;
      dblBufQ <= 1'b0;
      clkSelQ <= SEL_DIV1;
    end else if (ctrlWr) begin
      runQ    <= regWdata[RunBit];
      clrEnQ  <= regWdata[ClrBit];
      dblBufQ <= regWdata[DblBufBit];
      clkSelQ <= clkSelE'(regWdata[SelHi:SelLo]);
    end
  end

  // synchronizer for the external count clock
  logic [SyncTop:0] syncQ;
  logic             extPrevQ;
  logic             extEdge;

  generate
    if (SyncStages == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extClkIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SyncTop-1:0], extClkIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrevQ <= 1'b0;
    else       extPrevQ <= syncQ[SyncTop];
  end

  assign extEdge = syncQ[SyncTop] & ~extPrevQ;

  logic tickSel;
  always_comb begin
    unique case (clkSelQ)
      SEL_DIV1:  tickSel = tickDiv1;
      SEL_DIV4:  tickSel = tickDiv4;
      SEL_DIV16: tickSel = tickDiv16;
      SEL_EXT:   tickSel = extEdge;
      default:   tickSel = 1'b0;
    endcase
  end

  assign strb.countEn    = runQ & tickSel;
  assign strb.holdZero   = ~runQ;
  assign strb.clrOnMatch = clrEnQ;

  // writes pass straight to the active register unless buffered and running
  logic passThru;
  logic doReload;
  assign passThru = ~dblBufQ | ~runQ;
  assign doReload = reloadHit & dblBufQ & runQ;

  generate
    for (genvar k = 0; k < NumCmp; k++) begin : g_cmp
      logic [CntW-1:0] bufQ;
      logic [CntW-1:0] actQ;
      logic            wrHit;

      assign wrHit = regWe && (regAddr == ((k == 0) ? ADDR_CMP0 : ADDR_CMP1));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bufQ <= '0;
          actQ <= '0;
        end else begin
          if (wrHit) bufQ <= regWdata;
          if (wrHit && passThru) actQ <= regWdata;
          else if (doReload)     actQ <= bufQ;
        end
      end

      assign cmpAct[k] = actQ;
    end
  endgenerate

  // R10
  stopped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CMP1 && !runQ) |=> (cmpAct[1] == $past(regWdata)));

  // R9
  buffered_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dblBufQ && runQ && !reloadHit) |=> $stable(cmpAct[1]));

  // R8
  ext_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    extEdge |=> !extEdge);

endmodule

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobeT              strb,
  input  logic [1:0][CntW-1:0]  cmpAct,
  output logic [CntW-1:0]       cnt,
  output logic [1:0]            matchPulse,
  output logic                  ovfIrq,
  output logic                  reloadHit
);

  localparam int NumCmp = 2;
  localparam logic [CntW-1:0] CntMax = {CntW{1'b1}};

  logic [CntW-1:0] cntQ;
  logic            advQ;   // counter stepped in the previous cycle
  logic            ovfQ;
  logic [NumCmp-1:0] eq;

  generate
    for (genvar k = 0; k < NumCmp; k++) begin : g_eq
      assign eq[k]         = (cntQ == cmpAct[k]);
      assign matchPulse[k] = advQ & eq[k] & ~strb.holdZero;
    end
  endgenerate

  logic clearHit;
  logic wrapHit;
  assign clearHit  = strb.clrOnMatch & eq[1];
  assign wrapHit   = strb.countEn & (cntQ == CntMax) & ~clearHit;
  assign reloadHit = matchPulse[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      advQ <= 1'b0;
      ovfQ <= 1'b0;
    end else if (strb.holdZero) begin
      cntQ <= '0;
      advQ <= 1'b0;
      ovfQ <= 1'b0;
    end else if (strb.countEn) begin
      cntQ <= clearHit ? '0 : cntQ + 1'b1;
      advQ <= 1'b1;
      ovfQ <= wrapHit;
    end else begin
      advQ <= 1'b0;
      ovfQ <= 1'b0;
    end
  end

  assign cnt    = cntQ;
  assign ovfIrq = ovfQ;

  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdZero |=> (cntQ == '0) && !ovfQ);

  // R2
  stable_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.holdZero) |=> $stable(cntQ));

  // R7
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> (cntQ == '0) && ($past(cntQ) == CntMax));

  // R6
  clear_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse[1] && strb.clrOnMatch && strb.countEn) |=> (cntQ == '0));

  // R5
  match_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse[0] |-> $past(strb.countEn));

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
#(
  parameter int CntW       = 16,
  parameter int SyncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [1:0]      regAddr,
  input  logic [CntW-1:0] regWdata,
  input  logic            tickDiv1,
  input  logic            tickDiv4,
  input  logic            tickDiv16,
  input  logic            extClkIn,
  output logic [CntW-1:0] countVal,
  output logic            match0Pulse,
  output logic            match1Pulse,
  output logic            ovfIrq
);

  dpStrobeT             strb;
  logic [1:0][CntW-1:0] cmpAct;
  logic [1:0]           matchPulse;
  logic                 reloadHit;

  cmp_timer_ctrl #(.CntW(CntW), .SyncStages(SyncStages)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .tickDiv1  (tickDiv1),
    .tickDiv4  (tickDiv4),
    .tickDiv16 (tickDiv16),
    .extClkIn  (extClkIn),
    .reloadHit (reloadHit),
    .strb      (strb),
    .cmpAct    (cmpAct)
  );

  cmp_timer_dp #(.CntW(CntW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmpAct     (cmpAct),
    .cnt        (countVal),
    .matchPulse (matchPulse),
    .ovfIrq     (ovfIrq),
    .reloadHit  (reloadHit)
  );

  assign match0Pulse = matchPulse[0];
  assign match1Pulse = matchPulse[1];

endmodule

// File: tb/cmp_timer_chan_bench.sv
module cmp_timer_chan_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = 16'd0;
  logic        extClkIn = 1'b0;
  logic        tickDiv1, tickDiv4, tickDiv16;
  logic [15:0] countVal;
  logic        match0Pulse, match1Pulse, ovfIrq;

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  logic [3:0] tc = 4'd0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    tc  <= tc + 4'd1;
  end
  assign tickDiv1  = 1'b1;
  assign tickDiv4  = (tc[1:0] == 2'd3);
  assign tickDiv16 = (tc == 4'd15);

  cmp_timer_chan u_cmp_timer_chan (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .tickDiv1(tickDiv1), .tickDiv4(tickDiv4), .tickDiv16(tickDiv16), .extClkIn(extClkIn),
    .countVal(countVal), .match0Pulse(match0Pulse), .match1Pulse(match1Pulse), .ovfIrq(ovfIrq)
  );

  typedef struct {
    int          at;
    bit          chkCnt;
    logic [15:0] cnt;
    logic [2:0]  mask;   // {ovf, m1, m0}
    logic [2:0]  flags;
    string       tag;
  } expItemT;

  expItemT q[$];
  expItemT monItem;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  task automatic expectAt(input int at, input bit chkCnt, input logic [15:0] c,
                          input logic [2:0] mask, input logic [2:0] flags, input string tag);
    expItemT it;
    it.at = at; it.chkCnt = chkCnt; it.cnt = c; it.mask = mask; it.flags = flags; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops items due this cycle and compares against the ports
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      monItem = q.pop_front();
      compared++;
      if (monItem.at < cyc) begin
        mismatched++;
        $display("FAIL %s missed sample actual=cycle %0d expected=cycle %0d", monItem.tag, cyc, monItem.at);
      end else if ((monItem.chkCnt && countVal !== monItem.cnt) ||
                   (({ovfIrq, match1Pulse, match0Pulse} & monItem.mask) !== (monItem.flags & monItem.mask))) begin
        mismatched++;
        $display("FAIL %s at cycle %0d actual cnt=%h pulses=%b expected cnt=%h pulses=%b mask=%b",
                 monItem.tag, cyc, countVal, {ovfIrq, match1Pulse, match0Pulse},
                 monItem.cnt, monItem.flags, monItem.mask);
      end
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d, output int c0);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    #1 c0 = cyc;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic [15:0] ctrlWord(input bit run, input logic [1:0] sel,
                                           input bit clr, input bit dbl);
    return {11'd0, dbl, clr, sel, run};
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    int c0;
    int dummy;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectAt(cyc + 2, 1, 16'd0, 3'b111, 3'b000, "R1 reset");
    waitUntil(cyc + 4);

    writeReg(2'd2, 16'd100, dummy);
    writeReg(2'd1, 16'd3, dummy);

    // R2 counting, R5 compare 0 match
    writeReg(2'd0, ctrlWord(1, 2'd0, 0, 0), c0);
    expectAt(c0 + 2,  1, 16'd2,  3'b001, 3'b000, "R5 no early match0");
    expectAt(c0 + 3,  1, 16'd3,  3'b001, 3'b001, "R5 match0 pulse");
    expectAt(c0 + 4,  1, 16'd4,  3'b001, 3'b000, "R5 match0 one cycle");
    expectAt(c0 + 10, 1, 16'd10, 3'b000, 3'b000, "R2 count by one");
    waitUntil(c0 + 12);

    // R3 stop clears
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), c0);
    expectAt(c0 + 1, 1, 16'd0, 3'b100, 3'b000, "R3 stop clears");
    expectAt(c0 + 5, 1, 16'd0, 3'b000, 3'b000, "R3 stays zero");
    waitUntil(c0 + 6);

    // R4 divide-by-4 and divide-by-16 taps
    writeReg(2'd0, ctrlWord(1, 2'd1, 0, 0), c0);
    expectAt(c0 + 40, 1, 16'd10, 3'b000, 3'b000, "R4 div4 tap");
    waitUntil(c0 + 41);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);
    writeReg(2'd0, ctrlWord(1, 2'd2, 0, 0), c0);
    expectAt(c0 + 160, 1, 16'd10, 3'b000, 3'b000, "R4 div16 tap");
    waitUntil(c0 + 161);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);

    // R8 external pin, R4 code 3
    writeReg(2'd0, ctrlWord(1, 2'd3, 0, 0), c0);
    for (int i = 0; i < 7; i++) begin
      extClkIn = 1'b1; repeat (4) @(negedge clk);
      extClkIn = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    expectAt(cyc + 1, 1, 16'd7, 3'b000, 3'b000, "R8 R4 external edges");
    waitUntil(cyc + 2);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);

    // R6 clear on match with compare 1
    writeReg(2'd2, 16'd4, dummy);
    writeReg(2'd0, ctrlWord(1, 2'd0, 1, 0), c0);
    expectAt(c0 + 3,  1, 16'd3, 3'b011, 3'b001, "R5 match0 in period");
    expectAt(c0 + 4,  1, 16'd4, 3'b011, 3'b010, "R6 match1 pulse");
    expectAt(c0 + 5,  1, 16'd0, 3'b110, 3'b000, "R6 cleared, no overflow");
    expectAt(c0 + 9,  1, 16'd4, 3'b010, 3'b010, "R6 second period match1");
    expectAt(c0 + 10, 1, 16'd0, 3'b010, 3'b000, "R6 second clear");
    waitUntil(c0 + 11);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);

    // R6 free running past compare 1
    writeReg(2'd0, ctrlWord(1, 2'd0, 0, 0), c0);
    expectAt(c0 + 4, 1, 16'd4, 3'b010, 3'b010, "R6 match1 free-run");
    expectAt(c0 + 5, 1, 16'd5, 3'b010, 3'b000, "R6 no clear when disabled");
    waitUntil(c0 + 6);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);

    // R11 immediate write while running, buffering off
    writeReg(2'd2, 16'd20, dummy);
    writeReg(2'd0, ctrlWord(1, 2'd0, 1, 0), c0);
    expectAt(c0 + 6, 1, 16'd6, 3'b010, 3'b010, "R11 new compare in force");
    expectAt(c0 + 7, 1, 16'd0, 3'b000, 3'b000, "R11 clear at new compare");
    writeReg(2'd2, 16'd6, dummy);
    waitUntil(c0 + 8);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);

    // R10 stopped write immediate with buffering on, R9 buffered reload
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 1), dummy);
    writeReg(2'd2, 16'd5, dummy);
    writeReg(2'd0, ctrlWord(1, 2'd0, 1, 1), c0);
    expectAt(c0 + 5,  1, 16'd5, 3'b010, 3'b010, "R10 R9 old compare still active");
    expectAt(c0 + 6,  1, 16'd0, 3'b010, 3'b000, "R9 clear at old compare");
    expectAt(c0 + 13, 1, 16'd7, 3'b010, 3'b000, "R9 no match before reload value");
    expectAt(c0 + 14, 1, 16'd8, 3'b010, 3'b010, "R9 reloaded compare match");
    expectAt(c0 + 15, 1, 16'd0, 3'b000, 3'b000, "R9 period from reload");
    writeReg(2'd2, 16'd8, dummy);
    waitUntil(c0 + 16);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);

    // R7 overflow
    writeReg(2'd2, 16'd100, dummy);
    writeReg(2'd0, ctrlWord(1, 2'd0, 0, 0), c0);
    expectAt(c0 + 65535, 1, 16'hFFFF, 3'b100, 3'b000, "R7 before wrap");
    expectAt(c0 + 65536, 1, 16'h0000, 3'b100, 3'b100, "R7 overflow pulse");
    expectAt(c0 + 65537, 1, 16'h0001, 3'b100, 3'b000, "R7 overflow one cycle");
    waitUntil(c0 + 65539);
    writeReg(2'd0, ctrlWord(0, 2'd0, 0, 0), dummy);

    repeat (3) @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule